// File: doc/BRIEF.md
# DDR Refresh Interval Scheduler

This block paces AUTO REFRESH work for a DDR SDRAM controller. A free-running interval timer fires once per average refresh period, and every firing adds one to a count of refreshes still owed. While that count is above zero the block asks the command arbiter for a refresh slot. When the count reaches its ceiling of eight, the block also raises an urgent flag that the arbiter must obey. Each grant the block accepts settles one owed refresh.

After a refresh is accepted, the block holds off every command for the refresh recovery time. After a self-refresh exit strobe, it holds off non-READ commands for one recovery time and READ commands for a longer one. It reports these hold-offs on two flags. A refresh grant that arrives while commands are held off is ignored. So is a grant that arrives when nothing is owed.

All times are given in picoseconds together with the clock period, except the READ hold-off after self-refresh, which is given directly in cycles. The block converts the other times to cycle counts when it is elaborated. The refresh interval is rounded down so that the average rate is never too slow. The recovery windows are rounded up so that they are never too short.

Top module: `ddr_refresh_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, ref_req_o, ref_urgent_o, rd_block_o and cmd_block_o are all 0.
- R2: The owed count rises by one every REFI_CYC = floor(REFI_PS / CLK_PERIOD_PS) cycles, counted from the release of reset. ref_req_o is 1 exactly when the owed count is nonzero.
- R3: An accepted grant (ref_grant_i high while ref_req_o is 1 and cmd_block_o is 0) lowers the owed count by one. ref_req_o falls only as a result of an accepted grant.
- R4: ref_urgent_o is 1 exactly when the owed count equals MAX_OWED (8 by default). It is never 1 without ref_req_o.
- R5: The owed count saturates at MAX_OWED. Interval expiries while it is full add nothing.
- R6: After an accepted grant, both cmd_block_o and rd_block_o are 1 for the next RFC_CYC = ceil(RFC_PS / CLK_PERIOD_PS) cycles and then fall, unless another window keeps them high.
- R7: A grant that arrives while cmd_block_o is 1 is ignored. It does not change the owed count and does not restart the recovery window.
- R8: A grant that arrives while the owed count is zero is ignored. The count stays at zero and no hold-off starts.
- R9: After a sr_exit_i pulse, cmd_block_o is 1 for the next XSNR_CYC = ceil(XSNR_PS / CLK_PERIOD_PS) cycles. rd_block_o is 1 for the next XSRD_CYC cycles.
- R10: When an interval expiry and an accepted grant fall in the same cycle, the owed count stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_grant_i | input | 1 | Arbiter grants the refresh slot this cycle |
| sr_exit_i | input | 1 | Single-cycle strobe: the device has just left self-refresh |
| ref_req_o | output | 1 | At least one refresh is owed |
| ref_urgent_o | output | 1 | The owed count is at its ceiling; the arbiter must grant |
| rd_block_o | output | 1 | READ commands must not be issued |
| cmd_block_o | output | 1 | Non-READ commands, including refresh, must not be issued |

## Verification
The bench uses a 20000 ps clock period and a 400000 ps refresh interval. This gives a 20-cycle interval, so the owed count reaches its ceiling of eight within about 160 cycles, and the bench then runs three more interval expiries against the full count. The refresh recovery time is 70000 ps, which rounds up from 3.5 to 4 cycles. The non-READ hold-off is 75000 ps, which rounds up from 3.75 to 4 cycles. The READ hold-off is set to 12 cycles so that the two self-refresh windows end at visibly different times. With these values, an accepted grant can be placed exactly on an interval expiry, and grants can be made to arrive inside every window.

// File: rtl/ddr_refsched_pkg.sv
package ddr_refsched_pkg;

    // Index of each recovery window in the hold-timer array
    typedef enum int unsigned {
        HOLD_RFC  = 0,
        HOLD_XSNR = 1,
        HOLD_XSRD = 2
    } hold_idx_e;

    localparam int unsigned NUM_HOLD = 3;

    // Smallest cycle count that covers a time (recovery windows)
    function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    // Largest cycle count that does not exceed a time (average interval)
    function automatic int unsigned cyc_floor(input int unsigned t_ps, input int unsigned clk_ps);
        return t_ps / clk_ps;
    endfunction

endpackage

// File: rtl/refsched_interval_timer.sv
module refsched_interval_timer #(
    parameter int unsigned PERIOD_CYC = 3120
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int unsigned W = $clog2(PERIOD_CYC + 1);
    localparam logic [W-1:0] RELOAD = W'(PERIOD_CYC - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.cnt = RELOAD;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cnt <= RELOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == '0);

endmodule

// File: rtl/refsched_owed_counter.sv
module refsched_owed_counter #(
    parameter int unsigned MAX_OWED = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic inc_i,
    input  logic dec_i,
    output logic nonzero_o,
    output logic full_o
);
    localparam int unsigned W = $clog2(MAX_OWED + 1);
    localparam logic [W-1:0] CEIL = W'(MAX_OWED);

    typedef struct packed {
        logic [W-1:0] owed;
    } cnt_t;

    cnt_t st_d, st_q;
    logic dec_ok;
    logic at_ceil;

    assign at_ceil = (st_q.owed == CEIL);
    assign dec_ok  = dec_i && (st_q.owed != '0);

    always_comb begin
        st_d = st_q;
        unique case ({inc_i, dec_ok})
            2'b10: if (!at_ceil) st_d.owed = st_q.owed + 1'b1;
            2'b01: st_d.owed = st_q.owed - 1'b1;
            default: st_d.owed = st_q.owed;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.owed <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nonzero_o = (st_q.owed != '0);
    assign full_o    = at_ceil;

endmodule

// File: rtl/refsched_hold_timer.sv
module refsched_hold_timer #(
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned W = $clog2(HOLD_CYC + 2);
    localparam logic [W-1:0] LOAD = W'(HOLD_CYC);

    typedef struct packed {
        logic [W-1:0] left;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.left = LOAD;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.left <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.left != '0);

endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
    import ddr_refsched_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 2500,
    parameter int unsigned REFI_PS       = 7800000,
    parameter int unsigned RFC_PS        = 70000,
    parameter int unsigned XSNR_PS       = 75000,
    parameter int unsigned XSRD_CYC      = 200,
    parameter int unsigned MAX_OWED      = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ref_grant_i,
    input  logic sr_exit_i,
    output logic ref_req_o,
    output logic ref_urgent_o,
    output logic rd_block_o,
    output logic cmd_block_o
);
    localparam int unsigned REFI_CYC = cyc_floor(REFI_PS, CLK_PERIOD_PS);
    localparam int unsigned RFC_CYC  = cyc_ceil(RFC_PS, CLK_PERIOD_PS);
    localparam int unsigned XSNR_CYC = cyc_ceil(XSNR_PS, CLK_PERIOD_PS);

    function automatic int unsigned hold_len(input int unsigned idx);
        case (idx)
            HOLD_RFC:  return RFC_CYC;
            HOLD_XSNR: return XSNR_CYC;
            default:   return XSRD_CYC;
        endcase
    endfunction

    logic                tick;
    logic                owed_nz;
    logic                owed_full;
    logic                grant_acc;
    logic [NUM_HOLD-1:0] start_vec;
    logic [NUM_HOLD-1:0] busy_vec;
    logic                nonrd_busy;

    refsched_interval_timer #(
        .PERIOD_CYC(REFI_CYC)
    ) u_interval (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(tick)
    );

    refsched_owed_counter #(
        .MAX_OWED(MAX_OWED)
    ) u_owed (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .inc_i    (tick),
        .dec_i    (grant_acc),
        .nonzero_o(owed_nz),
        .full_o   (owed_full)
    );

    // A grant counts only with something owed and no window open
    assign nonrd_busy = busy_vec[HOLD_RFC] | busy_vec[HOLD_XSNR];
    assign grant_acc  = ref_grant_i & owed_nz & ~nonrd_busy;

    always_comb begin
        start_vec            = '0;
        start_vec[HOLD_RFC]  = grant_acc;
        start_vec[HOLD_XSNR] = sr_exit_i;
        start_vec[HOLD_XSRD] = sr_exit_i;
    end

    for (genvar g = 0; g < NUM_HOLD; g++) begin : g_hold
        refsched_hold_timer #(
            .HOLD_CYC(hold_len(g))
        ) u_hold (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .start_i(start_vec[g]),
            .busy_o (busy_vec[g])
        );
    end

    assign ref_req_o    = owed_nz;
    assign ref_urgent_o = owed_full;
    assign cmd_block_o  = nonrd_busy;
    assign rd_block_o   = |busy_vec;

endmodule

// File: rtl/ddr_refresh_sched_chk.sv
module ddr_refresh_sched_chk (
    input logic clk_i,
    input logic rst_i,
    input logic ref_grant_i,
    input logic sr_exit_i,
    input logic ref_req_o,
    input logic ref_urgent_o,
    input logic rd_block_o,
    input logic cmd_block_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (!ref_req_o && !ref_urgent_o && !rd_block_o && !cmd_block_o));

    // R4
    urgent_has_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ref_urgent_o |-> ref_req_o);

    // R5
    urgent_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_urgent_o && !(ref_grant_i && !cmd_block_o)) |=> ref_urgent_o);

    // R3
    req_drop_by_grant_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ref_req_o) |-> $past(ref_grant_i && !cmd_block_o));

    // R6
    grant_blocks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_grant_i && ref_req_o && !cmd_block_o) |=> (cmd_block_o && rd_block_o));

    // R7
    blocked_grant_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_block_o && ref_req_o) |=> ref_req_o);

    // R8
    idle_grant_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_grant_i && !ref_req_o && !cmd_block_o && !sr_exit_i) |=> !cmd_block_o);

    // R9
    sr_exit_blocks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sr_exit_i |=> (cmd_block_o && rd_block_o));

endmodule

bind ddr_refresh_sched ddr_refresh_sched_chk u_chk (.*);

// File: tb/sim_ddr_refresh_sched.sv
`timescale 1ns/1ps
module sim_ddr_refresh_sched;
    localparam int REFI = 20;

    logic clk = 1'b0;
    logic rst;
    logic ref_grant;
    logic sr_exit;
    logic ref_req, ref_urgent, rd_block, cmd_block;

    int n_checks = 0;
    int n_errors = 0;
    int edge_n   = 0;
    int exp_owed = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ddr_refresh_sched #(
        .CLK_PERIOD_PS(20000),
        .REFI_PS      (400000),
        .RFC_PS       (70000),
        .XSNR_PS      (75000),
        .XSRD_CYC     (12),
        .MAX_OWED     (8)
    ) u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .ref_grant_i (ref_grant),
        .sr_exit_i   (sr_exit),
        .ref_req_o   (ref_req),
        .ref_urgent_o(ref_urgent),
        .rd_block_o  (rd_block),
        .cmd_block_o (cmd_block)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at edge %0d: actual %b expected %b", what, edge_n, act, exp);
        end
    endtask

    task automatic chk_req(input string tag);
        check(ref_req,    exp_owed != 0, {tag, " ref_req"});
        check(ref_urgent, exp_owed == 8, {tag, " ref_urgent"});
    endtask

    task automatic chk_blk(input logic rd, input logic nrd, input string tag);
        check(rd_block,  rd,  {tag, " rd_block"});
        check(cmd_block, nrd, {tag, " cmd_block"});
    endtask

    // One clock edge; acc says whether the requirements make the grant count
    task automatic step(input logic g, input logic sx, input logic acc);
        bit tick;
        ref_grant = g;
        sr_exit   = sx;
        @(posedge clk);
        edge_n++;
        tick = (edge_n % REFI) == 0;
        if (tick && !acc) begin
            if (exp_owed < 8) exp_owed++;
        end else if (!tick && acc) begin
            exp_owed--;
        end
        #1;
        ref_grant = 1'b0;
        sr_exit   = 1'b0;
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        ref_grant = 1'b0;
        sr_exit   = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_blk(1'b0, 1'b0, "R1 in reset");
        check(ref_req, 1'b0, "R1 in reset ref_req");
        rst      = 1'b0;
        edge_n   = 0;
        exp_owed = 0;
    endtask

    task automatic idle_to(input int e, input string tag);
        while (edge_n < e) begin
            step(1'b0, 1'b0, 1'b0);
            chk_req(tag);
        end
    endtask

    task automatic t_reset();
        do_reset();
        step(1'b0, 1'b0, 1'b0);
        chk_req("R1 after reset");
        chk_blk(1'b0, 1'b0, "R1 after reset");
    endtask

    task automatic t_interval();
        do_reset();
        idle_to(19, "R2 before expiry");
        check(ref_req, 1'b0, "R2 edge 19 ref_req");
        step(1'b0, 1'b0, 1'b0);
        check(ref_req, 1'b1, "R2 edge 20 ref_req");
    endtask

    task automatic t_grant_window();
        do_reset();
        idle_to(20, "R2");
        step(1'b1, 1'b0, 1'b1);
        chk_req("R3 after grant");
        chk_blk(1'b1, 1'b1, "R6 edge 21");
        repeat (3) begin
            step(1'b0, 1'b0, 1'b0);
            chk_blk(1'b1, 1'b1, "R6 window");
        end
        step(1'b0, 1'b0, 1'b0);
        chk_blk(1'b0, 1'b0, "R6 window end");
    endtask

    task automatic t_blocked_grant();
        do_reset();
        idle_to(40, "R2");
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        chk_req("R7 grant in window");
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk_blk(1'b1, 1'b1, "R7 window");
        step(1'b0, 1'b0, 1'b0);
        chk_blk(1'b0, 1'b0, "R7 window not restarted");
        chk_req("R7 count kept");
        step(1'b1, 1'b0, 1'b1);
        chk_req("R7 final grant");
    endtask

    task automatic t_idle_grant();
        do_reset();
        step(1'b1, 1'b0, 1'b0);
        chk_req("R8 grant with none owed");
        chk_blk(1'b0, 1'b0, "R8 no window");
        idle_to(20, "R8 count stays zero");
        check(ref_req, 1'b1, "R8 first expiry");
    endtask

    task automatic t_same_cycle();
        do_reset();
        idle_to(39, "R2");
        step(1'b1, 1'b0, 1'b1);
        chk_req("R10 expiry with grant");
        chk_blk(1'b1, 1'b1, "R10 window");
        idle_to(44, "R10");
        chk_blk(1'b0, 1'b0, "R10 window end");
        step(1'b1, 1'b0, 1'b1);
        chk_req("R10 drain");
    endtask

    task automatic t_saturate();
        do_reset();
        idle_to(159, "R4");
        check(ref_urgent, 1'b0, "R4 seven owed");
        step(1'b0, 1'b0, 1'b0);
        check(ref_urgent, 1'b1, "R4 eight owed");
        idle_to(225, "R5 saturated");
        while (exp_owed != 0) begin
            step(1'b1, 1'b0, 1'b1);
            chk_req("R5 drain");
            repeat (4) begin
                step(1'b0, 1'b0, 1'b0);
                chk_req("R5 drain");
            end
        end
        check(ref_req, 1'b0, "R5 drained from ceiling");
    endtask

    task automatic t_sr_exit();
        do_reset();
        idle_to(20, "R2");
        step(1'b0, 1'b1, 1'b0);
        chk_blk(1'b1, 1'b1, "R9 exit edge");
        step(1'b1, 1'b0, 1'b0);
        chk_req("R9 grant in non-READ window");
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk_blk(1'b1, 1'b1, "R9 edge 24");
        step(1'b0, 1'b0, 1'b0);
        chk_blk(1'b1, 1'b0, "R9 edge 25");
        step(1'b1, 1'b0, 1'b1);
        chk_req("R9 grant after window");
        chk_blk(1'b1, 1'b1, "R9 refresh window");
        idle_to(32, "R9");
        chk_blk(1'b1, 1'b0, "R9 edge 32");
        step(1'b0, 1'b0, 1'b0);
        chk_blk(1'b0, 1'b0, "R9 edge 33");
    endtask

    initial begin
        t_reset();
        t_interval();
        t_grant_window();
        t_blocked_grant();
        t_idle_grant();
        t_same_cycle();
        t_saturate();
        t_sr_exit();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule